// File: doc/BRIEF.md
# Line-Crossing Load/Store Splitter

This block accepts a single memory access, given as a byte address and a byte count of at most eight. It rewrites the access as two requests, each one line wide, over lines of sixteen bytes. The first request names the line that holds the starting byte. The second names the line after it. Each request carries a line index and a sixteen-bit byte-enable map. Bit *i* of a map selects byte *i* of that line. A pairwise conflict checker further down the pipeline consumes both requests. The two indices of one access always differ by exactly one, so the checker may assume the two halves of one access never collide.

The datapath is combinational. First the count becomes a unary run of ones. That run is shifted left by the byte offset within the line, which gives a 32-bit span over two lines. The span is then cut into a low half and a high half. Each half gets a flag that is high when its map is non-zero. A count above eight is clamped to eight and raises an error flag.

A result stage follows the datapath. Parameter `REG_OUT` chooses between two variants. With the default value 1, the stage is a registered slot with two states, `ST_EMPTY` and `ST_FULL`, and a valid/ready handshake on both sides. Its transitions are:
- **fill**: `ST_EMPTY` to `ST_FULL` when a request arrives.
- **drain**: `ST_FULL` to `ST_EMPTY` when the consumer takes the result and no new request is present.
- **refill**: `ST_FULL` to `ST_FULL` when the consumer takes the result in the same cycle that a new request is present.
- **hold**: `ST_FULL` to `ST_FULL` when the consumer is not ready.

With `REG_OUT` set to 0, the stage is a plain wire pass-through.

Top module: `ldst_line_splitter`

## Requirements
- R1: `lo_index` equals address bits [ADDR_W-1:4]. `hi_index` equals `lo_index` + 1.
- R2: Let L be the effective byte count. Let S be ((1<<L)-1) shifted left by address bits [3:0], taken over 32 bits. Then `lo_mask` is S[15:0] and `hi_mask` is S[31:16]. Bit i of a mask enables byte i of its line.
- R3: Address 0x05B with count 8 gives `lo_index` 0x05 with `lo_mask` 0xF800, and `hi_index` 0x06 with `hi_mask` 0x0007.
- R4: `lo_en` is 1 exactly when `lo_mask` is non-zero. `hi_en` is 1 exactly when `hi_mask` is non-zero. An access that stays inside one line has `hi_en` = 0.
- R5: A count of 0 gives both masks zero, both enables 0 and `len_err` 0.
- R6: A count above 8 is treated as 8, and `len_err` = 1. Any count of 8 or less gives `len_err` = 0.
- R7: When `lo_index` is all ones, `hi_index` wraps to 0. No carry is reported.
- R8: After reset, `out_valid` = 0 and `req_ready` = 1.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its result is shown with `out_valid` = 1 from that edge on. A full stage with `out_ready` = 1 and no new request becomes empty at the next edge.
- R10: While `out_valid` = 1 and `out_ready` = 0, `req_ready` = 0 and all result outputs hold their values.
- R11: With `out_ready` held at 1, a new request is accepted on every clock edge. Each result appears one edge after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Stage can take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_len | input | LEN_W | Byte count of the access |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| lo_index | output | ADDR_W-4 | Line index of the starting line |
| lo_mask | output | 16 | Byte enables in the starting line |
| lo_en | output | 1 | Starting line has enabled bytes |
| hi_index | output | ADDR_W-4 | Line index of the following line |
| hi_mask | output | 16 | Byte enables in the following line |
| hi_en | output | 1 | Following line has enabled bytes |
| len_err | output | 1 | Count was above 8 and was clamped |

## Verification
The hardest case to reach from the ports is the **refill** transition. In that case a held result leaves and a new request enters on the same edge. It needs the consumer to be stalled, a second request waiting at the input, and then ready raised while that request is still asserted. The stimulus parks one result under backpressure and keeps a second request asserted throughout. It then releases `out_ready` and checks that the second result replaces the first with no empty cycle between them. Index wrap and a line-crossing clamped count are reached through chosen table vectors that sit at the top line and at offset 12.

// File: rtl/ldst_split_pkg.sv
package ldst_split_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_t;

endpackage

// File: rtl/ldst_len_unary.sv
module ldst_len_unary #(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8,
    parameter int SPAN_W  = 32
) (
    input  logic [LEN_W-1:0]  len,
    output logic [SPAN_W-1:0] run,
    output logic              over
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] eff;

    always_comb begin
        over = (len > CAP);
        eff  = over ? CAP : len;
    end

    for (genvar k = 0; k < SPAN_W; k++) begin : g_run
        assign run[k] = (32'(eff) > k);
    end

endmodule

// File: rtl/ldst_span_place.sv
module ldst_span_place #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0]                       addr,
    input  logic [2*LINE_BYTES-1:0]                 run,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    idx_a,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    idx_b,
    output logic [LINE_BYTES-1:0]                   map_a,
    output logic [LINE_BYTES-1:0]                   map_b,
    output logic                                    use_a,
    output logic                                    use_b
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = ADDR_W - OFF_W;
    localparam int SPAN_W = 2 * LINE_BYTES;

    logic [OFF_W-1:0]  off;
    logic [SPAN_W-1:0] span;

    always_comb begin
        off   = addr[OFF_W-1:0];
        idx_a = addr[ADDR_W-1:OFF_W];
        idx_b = idx_a + IDX_W'(1);
        span  = run << off;
        map_a = span[LINE_BYTES-1:0];
        map_b = span[SPAN_W-1:LINE_BYTES];
        use_a = |map_a;
        use_b = |map_b;
    end

endmodule

// File: rtl/ldst_result_slot.sv
module ldst_result_slot
    import ldst_split_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    if (REG_OUT) begin : g_reg
        slot_state_t  state_q, state_d;
        logic [W-1:0] data_q;
        logic         take;

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                ST_EMPTY: if (in_valid)               state_d = ST_FULL;
                ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
                default:                              state_d = ST_EMPTY;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= ST_EMPTY;
            else        state_q <= state_d;
        end

        always_comb begin
            in_ready  = (state_q == ST_EMPTY) || out_ready;
            take      = in_valid && in_ready;
            out_valid = (state_q == ST_FULL);
            out_data  = data_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    data_q <= '0;
            else if (take) data_q <= in_data;
        end

        // R9
        a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
        // R10
        a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready && !in_valid) |=> (out_valid && $stable(out_data)));
        // R10
        a_r10_no_take: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |=> $stable(out_data));
        // R9
        a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_ready && !in_valid) |=> !out_valid);
    end else begin : g_wire
        always_comb begin
            out_valid = in_valid;
            in_ready  = out_ready;
            out_data  = in_data;
        end
    end

endmodule

// File: rtl/ldst_line_splitter.sv
module ldst_line_splitter #(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 4,
    parameter int MAX_LEN    = 8,
    parameter int LINE_BYTES = 16,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [LEN_W-1:0]                     req_len,
    output logic                                 out_valid,
    input  logic                                 out_ready,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] lo_index,
    output logic [LINE_BYTES-1:0]                lo_mask,
    output logic                                 lo_en,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] hi_index,
    output logic [LINE_BYTES-1:0]                hi_mask,
    output logic                                 hi_en,
    output logic                                 len_err
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = ADDR_W - OFF_W;
    localparam int SPAN_W = 2 * LINE_BYTES;
    localparam int PAY_W  = 2 * IDX_W + 2 * LINE_BYTES + 3;

    logic [SPAN_W-1:0]     run;
    logic                  over;
    logic [IDX_W-1:0]      ia, ib;
    logic [LINE_BYTES-1:0] ma, mb;
    logic                  ua, ub;
    logic [PAY_W-1:0]      pay_in, pay_out;

    ldst_len_unary #(
        .LEN_W  (LEN_W),
        .MAX_LEN(MAX_LEN),
        .SPAN_W (SPAN_W)
    ) u_unary (
        .len (req_len),
        .run (run),
        .over(over)
    );

    ldst_span_place #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES)
    ) u_place (
        .addr (req_addr),
        .run  (run),
        .idx_a(ia),
        .idx_b(ib),
        .map_a(ma),
        .map_b(mb),
        .use_a(ua),
        .use_b(ub)
    );

    assign pay_in = {over, ub, mb, ib, ua, ma, ia};

    ldst_result_slot #(
        .W      (PAY_W),
        .REG_OUT(REG_OUT)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_data  (pay_in),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (pay_out)
    );

    assign {len_err, hi_en, hi_mask, hi_index, lo_en, lo_mask, lo_index} = pay_out;

    // R1, R7
    a_r1_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (hi_index == lo_index + IDX_W'(1)));
    // R4
    a_r4_flags: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((lo_en == (lo_mask != '0)) && (hi_en == (hi_mask != '0))));
    // R6
    a_r6_clamp_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && len_err) |-> (($countones(lo_mask) + $countones(hi_mask)) == MAX_LEN));
    // R2
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($countones(lo_mask) + $countones(hi_mask)) <= MAX_LEN));

endmodule

// File: tb/ldst_line_splitter_bench.sv
module ldst_line_splitter_bench;
    localparam int PERIOD = 10;
    localparam int AW = 12;
    localparam int LW = 4;

    typedef struct packed {
        logic [11:0] addr;
        logic [3:0]  len;
        logic [7:0]  li;
        logic [15:0] lm;
        logic        le;
        logic [7:0]  hx;
        logic [15:0] hm;
        logic        he;
        logic        er;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{12'h05B, 4'd8,  8'h05, 16'hF800, 1'b1, 8'h06, 16'h0007, 1'b1, 1'b0},
        '{12'h120, 4'd4,  8'h12, 16'h000F, 1'b1, 8'h13, 16'h0000, 1'b0, 1'b0},
        '{12'h3FF, 4'd1,  8'h3F, 16'h8000, 1'b1, 8'h40, 16'h0000, 1'b0, 1'b0},
        '{12'h0FE, 4'd2,  8'h0F, 16'hC000, 1'b1, 8'h10, 16'h0000, 1'b0, 1'b0},
        '{12'h0FF, 4'd2,  8'h0F, 16'h8000, 1'b1, 8'h10, 16'h0001, 1'b1, 1'b0},
        '{12'hFF9, 4'd8,  8'hFF, 16'hFE00, 1'b1, 8'h00, 16'h0001, 1'b1, 1'b0},
        '{12'h234, 4'd0,  8'h23, 16'h0000, 1'b0, 8'h24, 16'h0000, 1'b0, 1'b0},
        '{12'h236, 4'd12, 8'h23, 16'h3FC0, 1'b1, 8'h24, 16'h0000, 1'b0, 1'b1},
        '{12'h00C, 4'd15, 8'h00, 16'hF000, 1'b1, 8'h01, 16'h000F, 1'b1, 1'b1},
        '{12'h568, 4'd8,  8'h56, 16'hFF00, 1'b1, 8'h57, 16'h0000, 1'b0, 1'b0},
        '{12'h0A7, 4'd4,  8'h0A, 16'h0780, 1'b1, 8'h0B, 16'h0000, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [7:0]    lo_index, hi_index;
    logic [15:0]   lo_mask, hi_mask;
    logic          lo_en, hi_en, len_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ldst_line_splitter #(
        .ADDR_W (AW),
        .LEN_W  (LW),
        .MAX_LEN(8),
        .LINE_BYTES(16),
        .REG_OUT(1'b1)
    ) u_ldst_line_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .out_valid(out_valid), .out_ready(out_ready),
        .lo_index(lo_index), .lo_mask(lo_mask), .lo_en(lo_en),
        .hi_index(hi_index), .hi_mask(hi_mask), .hi_en(hi_en),
        .len_err(len_err)
    );

    localparam int RW = 51;

    function automatic logic [RW-1:0] model(input logic [11:0] a, input logic [3:0] n);
        int          e;
        logic [31:0] s;
        logic [7:0]  i0;
        e  = (n > 8) ? 8 : int'(n);
        s  = ((32'd1 << e) - 32'd1) << a[3:0];
        i0 = a[11:4];
        return {i0, s[15:0], (s[15:0] != 0), i0 + 8'd1, s[31:16], (s[31:16] != 0), (n > 8)};
    endfunction

    function automatic logic [RW-1:0] seen();
        return {lo_index, lo_mask, lo_en, hi_index, hi_mask, hi_en, len_err};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [11:0] a, input logic [3:0] n);
        @(negedge clk);
        req_addr  = a;
        req_len   = n;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R8 req_ready after reset", 64'(req_ready), 64'd1);

        // Table walk: R1 R2 R4 R5 R6 R7
        for (int v = 0; v < 11; v++) begin
            send(VECS[v].addr, VECS[v].len);
            chk($sformatf("R1/R2/R4/R5/R6/R7 vector %0d", v), 64'(seen()),
                64'({VECS[v].li, VECS[v].lm, VECS[v].le, VECS[v].hx,
                     VECS[v].hm, VECS[v].he, VECS[v].er}));
            chk($sformatf("R9 valid vector %0d", v), 64'(out_valid), 64'd1);
        end

        // R3 worked example
        send(12'h05B, 4'd8);
        chk("R3 lo pair", 64'({lo_index, lo_mask}), 64'({8'h05, 16'hF800}));
        chk("R3 hi pair", 64'({hi_index, hi_mask}), 64'({8'h06, 16'h0007}));

        // R9 drain: no request, consumer ready
        @(negedge clk);
        chk("R9 drain to empty", 64'(out_valid), 64'd0);

        // R10 backpressure, then refill
        @(negedge clk);
        out_ready = 1'b0;
        req_addr  = 12'h05B;
        req_len   = 4'd8;
        req_valid = 1'b1;
        @(negedge clk);
        held      = model(12'h05B, 4'd8);
        req_addr  = 12'h0FF;
        req_len   = 4'd2;
        chk("R10 ready low when stalled", 64'(req_ready), 64'd0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk($sformatf("R10 held result cycle %0d", c), 64'({out_valid, seen()}), 64'({1'b1, held}));
        end
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 refill replaces result", 64'({out_valid, seen()}),
            64'({1'b1, model(12'h0FF, 4'd2)}));

        // R11 back-to-back
        for (int b = 0; b < 4; b++) begin
            req_addr  = 12'(12'h7F0 + 12'(b * 5));
            req_len   = 4'(b + 3);
            req_valid = 1'b1;
            @(negedge clk);
            chk($sformatf("R11 back-to-back %0d", b), 64'({out_valid, req_ready, seen()}),
                64'({1'b1, 1'b1, model(12'(12'h7F0 + 12'(b * 5)), 4'(b + 3))}));
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 empty after burst", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule